// File: doc/BRIEF.md
# Multicycle RISC Instruction Controller

This block executes a small 32-bit RISC instruction subset one instruction at a time. It does not overlap instructions. Every instruction passes through a common fetch step and a common decode step. The fetch step loads the instruction register and advances the program counter. The decode step latches two source operands. After that, each instruction class takes its own sequence of execute, memory and write-back steps. All stages share one ALU and one memory port.

The surrounding system supplies a single memory port that serves both instructions and data. Its read data must be valid in the same cycle as the address, and a write is committed on the clock edge while the write strobe is high. A debug read port exposes any register and the program counter. A halt output marks a stopped machine, and an error output marks a stop caused by an instruction the block does not recognise.

Top module: `rcpu_core`

## Requirements
- R1: While reset is low, the program counter reads 0, every register reads 0, and halt and error are low.
- R2: Fetch loads the instruction word from memory at the program counter and adds 4 to the program counter. The instruction fields are:
  - opcode: bits 31:26
  - first source rs: bits 25:21
  - second source rt: bits 20:16
  - destination rd: bits 15:11
  - function: bits 10:0
  - immediate: bits 15:0
  - jump target: bits 25:0
- R3: Opcode 0x00 is a register-register operation that writes rs op rt into rd. The function codes are:
  - 0x020: add
  - 0x022: subtract
  - 0x024: and
  - 0x025: or
  - 0x026: xor
  - 0x02A: signed set-less-than
- R4: A register-immediate operation combines rs with the sign-extended immediate and writes the result into rt. The opcodes are:
  - 0x08: add
  - 0x0A: signed set-less-than
  - 0x0C: and
  - 0x0D: or
  - 0x0E: xor
- R5: Load (opcode 0x23) reads the word at rs plus the sign-extended immediate and writes it into rt.
- R6: Store (opcode 0x2B) writes rt to memory at rs plus the sign-extended immediate. It writes no register and holds the write strobe for exactly one cycle.
- R7: Branch-if-zero (opcode 0x04) and branch-if-nonzero (opcode 0x05) test rs. When the condition holds, the program counter becomes the incremented program counter plus the immediate shifted left by 2.
- R8: Jump (opcode 0x02) sets the program counter to its own upper four bits joined with the target field shifted left by 2.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Opcode 0x3F stops the machine. Halt goes high, error stays low, and the program counter holds one word past the stop instruction from then on.
- R11: An opcode that is not listed in R3 to R10, or a register-register function code that is not listed in R3, stops the machine with both halt and error high.
- R12: The cycle count per instruction is:
  - register-register, register-immediate and load: 5
  - store: 4
  - branch and jump: 3
  - stop: 2 cycles before halt is seen

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 32 | Memory address: the program counter in fetch, the computed address otherwise |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle as mem_addr |
| dbg_raddr | input | 5 | Register index for the debug read |
| dbg_rdata | output | 32 | Contents of the register selected by dbg_raddr |
| dbg_pc | output | 32 | Current program counter |
| halted | output | 1 | Machine has stopped |
| error | output | 1 | Stop was caused by an unrecognised instruction |

## Verification
A wrong control state usually shows first at the memory port. A store strobe that appears outside its one cycle shows there, and so does a data access made during a fetch cycle. Either shows within the instruction that goes wrong. A wrong execute or write-back path leaves a bad value in a register, and that value becomes visible through the debug port once the program stops. A wrong program-counter update or a wrong step count changes the final program counter or the number of cycles to halt, and both are compared against values worked out from R12. A wrong operand latch corrupts every later result that reads that operand.

// File: rtl/rcpu_pkg.sv
// Shared types and instruction encodings for the multicycle controller.
// Assumes the fixed 32-bit instruction layout: opcode 31:26, rs 25:21,
// rt 20:16, rd 15:11, function 10:0, immediate 15:0, target 25:0.
package rcpu_pkg;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_EXE_RR, ST_EXE_RI, ST_EXE_ADR,
        ST_MEM_CP, ST_MEM_LD, ST_MEM_ST, ST_WB, ST_BRANCH, ST_JUMP, ST_HALT
    } ctl_state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_RR, CL_RI, CL_LD, CL_ST, CL_BR, CL_JMP, CL_STOP, CL_BAD
    } ins_class_e;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_JMP  = 6'h02;
    localparam logic [5:0] OPC_BEQZ = 6'h04;
    localparam logic [5:0] OPC_BNEZ = 6'h05;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_ANDI = 6'h0C;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_XORI = 6'h0E;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;
    localparam logic [5:0] OPC_STOP = 6'h3F;

    localparam logic [10:0] FN_ADD = 11'h020;
    localparam logic [10:0] FN_SUB = 11'h022;
    localparam logic [10:0] FN_AND = 11'h024;
    localparam logic [10:0] FN_OR  = 11'h025;
    localparam logic [10:0] FN_XOR = 11'h026;
    localparam logic [10:0] FN_SLT = 11'h02A;

    // Sorts an instruction into the class that picks its state path.
    function automatic ins_class_e classify(input logic [5:0] opc, input logic [10:0] fn);
        case (opc)
            OPC_REG: begin
                case (fn)
                    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLT: return CL_RR;
                    default: return CL_BAD;
                endcase
            end
            OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_XORI: return CL_RI;
            OPC_LW:               return CL_LD;
            OPC_SW:               return CL_ST;
            OPC_BEQZ, OPC_BNEZ:   return CL_BR;
            OPC_JMP:              return CL_JMP;
            OPC_STOP:             return CL_STOP;
            default:              return CL_BAD;
        endcase
    endfunction

    // Chooses the ALU operation from the opcode or the function field.
    function automatic alu_op_e alu_select(input logic [5:0] opc, input logic [10:0] fn);
        if (opc == OPC_REG) begin
            case (fn)
                FN_SUB:  return ALU_SUB;
                FN_AND:  return ALU_AND;
                FN_OR:   return ALU_OR;
                FN_XOR:  return ALU_XOR;
                FN_SLT:  return ALU_SLT;
                default: return ALU_ADD;
            endcase
        end
        case (opc)
            OPC_SLTI: return ALU_SLT;
            OPC_ANDI: return ALU_AND;
            OPC_ORI:  return ALU_OR;
            OPC_XORI: return ALU_XOR;
            default:  return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/rcpu_regfile.sv
// General register file with NRP combinational read ports and one write port.
// Entry 0 reads as zero and ignores writes. Every entry clears on reset.
module rcpu_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int NRP  = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(NREG)-1:0]       waddr,
    input  logic [XLEN-1:0]               wdata,
    input  logic [NRP-1:0][$clog2(NREG)-1:0] raddr,
    output logic [NRP-1:0][XLEN-1:0]      rdata
);
    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] regs [NREG];

    // Clear on reset; otherwise store the write value unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && waddr != AW'(0)) begin
            regs[waddr] <= wdata;
        end
    end

    // One read mux per port, entry 0 forced to zero.
    for (genvar p = 0; p < NRP; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == AW'(0)) ? '0 : regs[raddr[p]];
    end
endmodule

// File: rtl/rcpu_alu.sv
// Combinational ALU shared by the execute and address-calculation states.
module rcpu_alu
    import rcpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] res
);
    // Select the result of the requested operation.
    always_comb begin
        case (op)
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_XOR: res = opa ^ opb;
            ALU_SLT: res = ($signed(opa) < $signed(opb)) ? XLEN'(1) : '0;
            default: res = opa + opb;
        endcase
    end
endmodule

// File: rtl/rcpu_fsm.sv
// Control sequencer: shared fetch and decode, then a per-class state path.
// It assumes the instruction register is stable from decode until the next fetch.
module rcpu_fsm
    import rcpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  opc,
    input  logic [10:0] fn,
    output ctl_state_e  state,
    output logic        err
);
    ctl_state_e state_q, state_d;
    ins_class_e cls;
    logic       err_q;

    assign cls = classify(opc, fn);

    // Next-state selection for each control step.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                case (cls)
                    CL_RR:         state_d = ST_EXE_RR;
                    CL_RI:         state_d = ST_EXE_RI;
                    CL_LD, CL_ST:  state_d = ST_EXE_ADR;
                    CL_BR:         state_d = ST_BRANCH;
                    CL_JMP:        state_d = ST_JUMP;
                    default:       state_d = ST_HALT;
                endcase
            end
            ST_EXE_RR, ST_EXE_RI: state_d = ST_MEM_CP;
            ST_EXE_ADR: state_d = (opc == OPC_SW) ? ST_MEM_ST : ST_MEM_LD;
            ST_MEM_CP, ST_MEM_LD: state_d = ST_WB;
            ST_WB, ST_MEM_ST, ST_BRANCH, ST_JUMP: state_d = ST_FETCH;
            default:   state_d = ST_HALT;
        endcase
    end

    // State register and the sticky error flag set by an unknown instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DECODE && cls == CL_BAD) err_q <= 1'b1;
        end
    end

    assign state = state_q;
    assign err   = err_q;
endmodule

// File: rtl/rcpu_core.sv
// Multicycle RISC core: a datapath of PC, IR, A, B, result and write-back
// registers sequenced by rcpu_fsm. It assumes a memory port whose read data
// is valid in the same cycle as the address. XLEN must be 32 for the fixed
// instruction layout.
module rcpu_core
    import rcpu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [XLEN-1:0]         mem_addr,
    output logic                    mem_we,
    output logic [XLEN-1:0]         mem_wdata,
    input  logic [XLEN-1:0]         mem_rdata,
    input  logic [$clog2(NREG)-1:0] dbg_raddr,
    output logic [XLEN-1:0]         dbg_rdata,
    output logic [XLEN-1:0]         dbg_pc,
    output logic                    halted,
    output logic                    error
);
    localparam int AW = $clog2(NREG);
    localparam int NRP = 3;

    ctl_state_e      ctl_state;
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, rslt_q, wb_q;
    logic [5:0]      f_opc;
    logic [AW-1:0]   f_rs, f_rt, f_rd;
    logic [10:0]     f_fn;
    logic [25:0]     f_tgt;
    logic [XLEN-1:0] imm_sx, alu_b, alu_y;
    alu_op_e         alu_op;
    logic            br_take, rf_we;
    logic [AW-1:0]   rf_waddr;
    logic [NRP-1:0][AW-1:0]   rf_raddr;
    logic [NRP-1:0][XLEN-1:0] rf_rdata;

    assign f_opc  = ir_q[31:26];
    assign f_rs   = ir_q[25:21];
    assign f_rt   = ir_q[20:16];
    assign f_rd   = ir_q[15:11];
    assign f_fn   = ir_q[10:0];
    assign f_tgt  = ir_q[25:0];
    assign imm_sx = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

    rcpu_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .opc   (f_opc),
        .fn    (f_fn),
        .state (ctl_state),
        .err   (error)
    );

    assign rf_raddr = {dbg_raddr, f_rt, f_rs};
    assign rf_we    = (ctl_state == ST_WB);
    assign rf_waddr = (f_opc == OPC_REG) ? f_rd : f_rt;

    rcpu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRP(NRP)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (wb_q),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    assign alu_b  = (ctl_state == ST_EXE_RR) ? b_q : imm_sx;
    assign alu_op = (ctl_state == ST_EXE_ADR) ? ALU_ADD : alu_select(f_opc, f_fn);

    rcpu_alu #(.XLEN(XLEN)) u_alu (
        .opa (a_q),
        .opb (alu_b),
        .op  (alu_op),
        .res (alu_y)
    );

    assign br_take = (f_opc == OPC_BEQZ) ? (a_q == '0) : (a_q != '0);

    // Register transfers performed in each control state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ir_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            rslt_q <= '0;
            wb_q   <= '0;
        end else begin
            case (ctl_state)
                ST_FETCH: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + XLEN'(4);
                end
                ST_DECODE: begin
                    a_q <= rf_rdata[0];
                    b_q <= rf_rdata[1];
                end
                ST_EXE_RR, ST_EXE_RI, ST_EXE_ADR: rslt_q <= alu_y;
                ST_MEM_CP: wb_q <= rslt_q;
                ST_MEM_LD: wb_q <= mem_rdata;
                ST_BRANCH: if (br_take) pc_q <= pc_q + (imm_sx << 2);
                ST_JUMP:   pc_q <= {pc_q[XLEN-1:28], f_tgt, 2'b00};
                default: ;
            endcase
        end
    end

    assign mem_addr  = (ctl_state == ST_FETCH) ? pc_q : rslt_q;
    assign mem_we    = (ctl_state == ST_MEM_ST);
    assign mem_wdata = b_q;
    assign dbg_rdata = rf_rdata[2];
    assign dbg_pc    = pc_q;
    assign halted    = (ctl_state == ST_HALT);
endmodule

// File: rtl/rcpu_core_chk.sv
// Property checker for rcpu_core, attached through bind. It only observes signals.
module rcpu_core_chk
    import rcpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input ctl_state_e      state,
    input logic [XLEN-1:0] pc,
    input logic [4:0]      rs_field,
    input logic [XLEN-1:0] opnd_a,
    input logic            mem_we,
    input logic            halted,
    input logic            error,
    input logic [XLEN-1:0] dbg_pc
);
    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FETCH |=> pc == $past(pc) + XLEN'(4));

    assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && rs_field == 5'd0) |=> opnd_a == '0);

    assert_store_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we && state == ST_FETCH));

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(dbg_pc)));

    assert_error_halts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> halted);

    assert_no_store_halted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    assert_decode_moves_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DECODE |=> (state != ST_FETCH && state != ST_DECODE));
endmodule

bind rcpu_core rcpu_core_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (ctl_state),
    .pc       (pc_q),
    .rs_field (ir_q[25:21]),
    .opnd_a   (a_q),
    .mem_we   (mem_we),
    .halted   (halted),
    .error    (error),
    .dbg_pc   (dbg_pc)
);

// File: tb/rcpu_core_bench.sv
// Directed bench: each task loads a program, runs it to halt and checks results.
module rcpu_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_rdata, dbg_pc;
    logic        mem_we, halted, error;
    logic [4:0]  dbg_raddr = 5'd0;
    logic [31:0] mem [0:255];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rcpu_core u_rcpu_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dbg_raddr(dbg_raddr),
        .dbg_rdata(dbg_rdata), .dbg_pc(dbg_pc), .halted(halted), .error(error)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;

    function automatic logic [31:0] enc_r(input logic [10:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rt, input int rs, input int imm);
        return {opc, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(input int tgt);
        return {6'h02, tgt[25:0]};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic get_reg(input int idx, output logic [31:0] v);
        dbg_raddr = idx[4:0];
        #1;
        v = dbg_rdata;
    endtask

    task automatic check_reg(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        get_reg(idx, v);
        check(req, $sformatf("r%0d", idx), v, exp);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    endtask

    // Reset, release, then count rising edges until halt is seen.
    task automatic run_prog(output int cycles);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cycles = 0;
        while (!halted && cycles < 4000) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
        end
        if (!halted) check("R10", "program did not halt", 32'(cycles), 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "pc in reset", dbg_pc, 32'h0);
        check("R1", "halted in reset", {31'h0, halted}, 32'h0);
        check("R1", "error in reset", {31'h0, error}, 32'h0);
        check_reg("R1", 3, 32'h0);
        check_reg("R1", 31, 32'h0);
    endtask

    task automatic t_alu();
        int cyc;
        clear_mem();
        mem[0]  = enc_i(6'h08, 1, 0, 5);
        mem[1]  = enc_i(6'h08, 2, 0, -3);
        mem[2]  = enc_r(11'h020, 3, 1, 2);
        mem[3]  = enc_r(11'h022, 4, 1, 2);
        mem[4]  = enc_r(11'h024, 5, 1, 2);
        mem[5]  = enc_r(11'h025, 6, 1, 2);
        mem[6]  = enc_r(11'h026, 7, 1, 2);
        mem[7]  = enc_r(11'h02A, 8, 2, 1);
        mem[8]  = enc_r(11'h02A, 9, 1, 2);
        mem[9]  = enc_i(6'h0C, 10, 2, 32'h00F0);
        mem[10] = enc_i(6'h0D, 11, 1, 32'h8000);
        mem[11] = enc_i(6'h0E, 12, 1, 1);
        mem[12] = enc_i(6'h0A, 13, 2, 0);
        mem[13] = {6'h3F, 26'h0};
        run_prog(cyc);
        check_reg("R4", 2, 32'hFFFF_FFFD);
        check_reg("R3", 3, 32'h2);
        check_reg("R3", 4, 32'h8);
        check_reg("R3", 5, 32'h5);
        check_reg("R3", 6, 32'hFFFF_FFFD);
        check_reg("R3", 7, 32'hFFFF_FFF8);
        check_reg("R3", 8, 32'h1);
        check_reg("R3", 9, 32'h0);
        check_reg("R4", 10, 32'h0000_00F0);
        check_reg("R4", 11, 32'hFFFF_8005);
        check_reg("R4", 12, 32'h4);
        check_reg("R4", 13, 32'h1);
        check("R12", "alu program cycles", 32'(cyc), 32'(13 * 5 + 2));
    endtask

    task automatic t_loadstore();
        int cyc;
        clear_mem();
        mem[32] = 32'hDEAD_BEEF;
        mem[0] = enc_i(6'h08, 1, 0, 32'h40);
        mem[1] = enc_i(6'h2B, 1, 1, 8);
        mem[2] = enc_i(6'h23, 9, 1, 8);
        mem[3] = enc_i(6'h08, 2, 0, 32'h84);
        mem[4] = enc_i(6'h23, 10, 2, -4);
        mem[5] = enc_i(6'h2B, 10, 1, -4);
        mem[6] = {6'h3F, 26'h0};
        run_prog(cyc);
        check("R6", "store word at 0x48", mem[18], 32'h40);
        check_reg("R5", 9, 32'h40);
        check_reg("R5", 10, 32'hDEAD_BEEF);
        check("R6", "store at negative offset 0x3C", mem[15], 32'hDEAD_BEEF);
        check_reg("R6", 1, 32'h40);
        check("R12", "load/store cycles", 32'(cyc), 32'(5 + 4 + 5 + 5 + 5 + 4 + 2));
    endtask

    task automatic t_zero_reg();
        int cyc;
        clear_mem();
        mem[0] = enc_i(6'h08, 0, 0, 7);
        mem[1] = enc_r(11'h020, 11, 0, 0);
        mem[2] = enc_i(6'h08, 12, 0, 9);
        mem[3] = {6'h3F, 26'h0};
        run_prog(cyc);
        check_reg("R9", 0, 32'h0);
        check_reg("R9", 11, 32'h0);
        check_reg("R9", 12, 32'h9);
    endtask

    task automatic t_branch();
        int cyc;
        clear_mem();
        mem[0]  = enc_i(6'h08, 1, 0, 0);
        mem[1]  = enc_i(6'h04, 0, 1, 1);
        mem[2]  = enc_i(6'h08, 2, 0, 1);
        mem[3]  = enc_i(6'h08, 3, 0, 2);
        mem[4]  = enc_i(6'h05, 0, 1, 1);
        mem[5]  = enc_i(6'h08, 4, 0, 3);
        mem[6]  = enc_i(6'h08, 5, 0, 3);
        mem[7]  = enc_i(6'h08, 6, 6, 1);
        mem[8]  = enc_i(6'h08, 5, 5, -1);
        mem[9]  = enc_i(6'h05, 0, 5, -3);
        mem[10] = {6'h3F, 26'h0};
        run_prog(cyc);
        check_reg("R7", 2, 32'h0);
        check_reg("R7", 3, 32'h2);
        check_reg("R7", 4, 32'h3);
        check_reg("R7", 5, 32'h0);
        check_reg("R7", 6, 32'h3);
        check("R10", "pc after stop", dbg_pc, 32'h2C);
    endtask

    task automatic t_jump();
        int cyc;
        clear_mem();
        mem[0] = enc_j(4);
        mem[1] = enc_i(6'h08, 7, 0, 9);
        mem[4] = enc_i(6'h08, 8, 0, 1);
        mem[5] = {6'h3F, 26'h0};
        run_prog(cyc);
        check_reg("R8", 7, 32'h0);
        check_reg("R8", 8, 32'h1);
        check("R8", "pc after jump program", dbg_pc, 32'h18);
    endtask

    task automatic t_timing();
        int cyc;
        clear_mem();
        mem[0] = enc_i(6'h08, 1, 0, 5);
        mem[1] = enc_i(6'h2B, 1, 0, 32'h20);
        mem[2] = enc_i(6'h04, 0, 0, 0);
        mem[3] = enc_j(4);
        mem[4] = {6'h3F, 26'h0};
        run_prog(cyc);
        check("R12", "mixed class cycles", 32'(cyc), 32'd17);
        check("R6", "store of r1", mem[8], 32'h5);
    endtask

    task automatic t_stop();
        int cyc;
        logic [31:0] pc0;
        clear_mem();
        mem[0] = {6'h3F, 26'h0};
        run_prog(cyc);
        check("R12", "stop cycles", 32'(cyc), 32'd2);
        check("R10", "error after stop", {31'h0, error}, 32'h0);
        pc0 = dbg_pc;
        repeat (6) @(negedge clk);
        check("R10", "pc frozen", dbg_pc, pc0);
        check("R10", "still halted", {31'h0, halted}, 32'h1);
        check("R10", "pc value", pc0, 32'h4);
    endtask

    task automatic t_undefined();
        int cyc;
        clear_mem();
        mem[0] = enc_i(6'h08, 1, 0, 1);
        mem[1] = {6'h3E, 26'h0};
        run_prog(cyc);
        check("R11", "error on bad opcode", {31'h0, error}, 32'h1);
        check("R11", "pc after bad opcode", dbg_pc, 32'h8);
        check_reg("R11", 1, 32'h1);
        clear_mem();
        mem[0] = enc_r(11'h001, 3, 0, 0);
        run_prog(cyc);
        check("R11", "error on bad function", {31'h0, error}, 32'h1);
        check("R11", "halted on bad function", {31'h0, halted}, 32'h1);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        t_reset();
        t_alu();
        t_reset();
        t_loadstore();
        t_zero_reg();
        t_branch();
        t_jump();
        t_timing();
        t_stop();
        t_undefined();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule